// File: doc/BRIEF.md
# Edge/Level Programmable Interrupt Controller

This block gathers up to 32 interrupt request lines from the peripherals of a chip and turns them into one interrupt signal for a processor. Typical sources are timers, serial ports, a network physical layer, buffer managers and timing pulses. Each line is set up on its own. It can be level-sensitive, so it is pending for as long as its input sits at the active value. It can also be edge-triggered, so a transition toward the active value is latched until software clears it. A per-line polarity bit picks the active value or direction. A per-line mask bit, where 1 disables the line, gates the line's contribution to the combined output.

Software reaches the block through a small synchronous register port with a 2-bit word address. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address. There are four registers: trigger mode, polarity, mask and pending. Pending is read to find the requesting lines. Writing ones to it clears latched edges, and zero bits in that write leave their lines alone.

Request inputs are taken as synchronous to the block clock.

Top module: `irq_combiner`

## Requirements
- R1: After reset the trigger-mode register reads all zeros (every line level-sensitive), polarity reads all ones, mask reads all ones, pending reads zero and irqOut is low.
- R2: Register word addresses are 0 = trigger mode (1 = edge, 0 = level), 1 = polarity (1 = active-high / rising), 2 = mask (1 = disabled), 3 = pending. Addresses 0, 1 and 2 read back exactly what was last written to them.
- R3: For a level-sensitive line, the pending bit reads 1 in the same cycle its request input equals its polarity bit, and 0 otherwise.
- R4: For a level-sensitive line, writing a 1 to its pending bit has no effect: it keeps reading 1 while the input stays active, and reads 0 once the input goes inactive.
- R5: For an edge-triggered line, the pending bit is set on the clock edge after the input moves from inactive in one sampled cycle to active in the next. This is a 0-to-1 move when polarity is 1 and a 1-to-0 move when polarity is 0.
- R6: An edge-triggered pending bit stays set after the input returns inactive, until a write to address 3 carries a 1 in that bit. A write of 0 to that bit leaves it set.
- R7: When a new edge and a clearing write for the same line fall in the same cycle, the pending bit is set afterwards.
- R8: irqOut is high exactly when some pending bit has a mask bit of 0. It follows the pending state with no added register.
- R9: Switching a line from edge to level mode discards its latched edge, so switching it back to edge mode does not bring the old edge back.
- R10: An edge-triggered line whose input stays active without a new transition does not become pending; in particular, switching a line into edge mode does not latch an edge by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_LINES | Interrupt request inputs, one per line |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | BUS_W | Write data |
| regRdData | output | BUS_W | Read data of the addressed register, zero-extended |
| irqOut | output | 1 | Combined interrupt to the processor |

## Verification
The assertions check the following on every cycle:
- the reset values of mask and latched edges;
- that a latched edge survives any cycle that does not clear it;
- that an edge coinciding with a clear wins;
- that no latch remains on a level-mode line;
- that masking every line silences irqOut on the next cycle.

Only the bench scenarios can show the visible register behaviour. That covers level-mode pending following the input in both polarities, falling-edge capture, the futility of clearing an active level line, register readback, and the exact mix of masked and unmasked lines that drives irqOut.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;

  typedef enum logic [1:0] {
    REG_TRIG = 2'd0,
    REG_POL  = 2'd1,
    REG_MASK = 2'd2,
    REG_PEND = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrTrig;
    logic wrPol;
    logic wrMask;
    logic clrPend;
  } regStrobe_t;

endpackage

// File: rtl/irq_combiner_ctl.sv
module irq_combiner_ctl
  import irq_combiner_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int BUS_W     = 32
) (
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [BUS_W-1:0]     regWrData,
  input  logic [NUM_LINES-1:0] trigVec,
  input  logic [NUM_LINES-1:0] polVec,
  input  logic [NUM_LINES-1:0] maskVec,
  input  logic [NUM_LINES-1:0] pendVec,
  output regStrobe_t           strobe,
  output logic [NUM_LINES-1:0] wrBits,
  output logic [BUS_W-1:0]     regRdData
);

  regSel_e sel;
  assign sel    = regSel_e'(regAddr);
  assign wrBits = regWrData[NUM_LINES-1:0];

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      unique case (sel)
        REG_TRIG: strobe.wrTrig  = 1'b1;
        REG_POL:  strobe.wrPol   = 1'b1;
        REG_MASK: strobe.wrMask  = 1'b1;
        REG_PEND: strobe.clrPend = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_TRIG: regRdData = BUS_W'(trigVec);
      REG_POL:  regRdData = BUS_W'(polVec);
      REG_MASK: regRdData = BUS_W'(maskVec);
      REG_PEND: regRdData = BUS_W'(pendVec);
    endcase
  end

endmodule

// File: rtl/irq_combiner_dp.sv
module irq_combiner_dp
  import irq_combiner_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] wrBits,
  input  logic [NUM_LINES-1:0] reqIn,
  output logic [NUM_LINES-1:0] trigVec,
  output logic [NUM_LINES-1:0] polVec,
  output logic [NUM_LINES-1:0] maskVec,
  output logic [NUM_LINES-1:0] pendVec,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] trigReg, polReg, maskReg;
  logic [NUM_LINES-1:0] reqPrev, edgeLatch, edgeSeen, clrBits, levelActive;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigReg <= '0;
      polReg  <= '1;
      maskReg <= '1;
    end else begin
      if (strobe.wrTrig) trigReg <= wrBits;
      if (strobe.wrPol)  polReg  <= wrBits;
      if (strobe.wrMask) maskReg <= wrBits;
    end
  end

  assign clrBits = strobe.clrPend ? wrBits : '0;

  // per-line capture
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic nowActive, wasActive;
    assign nowActive      = ~(reqIn[i] ^ polReg[i]);
    assign wasActive      = ~(reqPrev[i] ^ polReg[i]);
    assign levelActive[i] = nowActive;
    assign edgeSeen[i]    = trigReg[i] & nowActive & ~wasActive;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqPrev[i]   <= 1'b0;
        edgeLatch[i] <= 1'b0;
      end else begin
        reqPrev[i]   <= reqIn[i];
        edgeLatch[i] <= trigReg[i] ? ((edgeLatch[i] & ~clrBits[i]) | edgeSeen[i]) : 1'b0;
      end
    end

    assign pendVec[i] = trigReg[i] ? edgeLatch[i] : levelActive[i];
  end

  assign trigVec = trigReg;
  assign polVec  = polReg;
  assign maskVec = maskReg;
  assign irqOut  = |(pendVec & ~maskReg);

  // R1: leaving reset, every line masked and no edge held
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskReg == '1 && edgeLatch == '0 && !irqOut));

  // R6: a held edge survives any cycle that does not clear it
  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch | ~$past(edgeLatch & trigReg & ~clrBits)) == '1));

  // R7: an edge arriving with a clear is kept
  p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch | ~$past(edgeSeen)) == '1));

  // R9: a line in level mode holds no edge afterwards
  p_level_drops_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch & ~$past(trigReg)) == '0));

  // R8: masking every line silences the output
  p_full_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrMask && wrBits == '1) |=> !irqOut);

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int BUS_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [BUS_W-1:0]     regWrData,
  output logic [BUS_W-1:0]     regRdData,
  output logic                 irqOut
);

  regStrobe_t           strobe;
  logic [NUM_LINES-1:0] wrBits, trigVec, polVec, maskVec, pendVec;

  irq_combiner_ctl #(.NUM_LINES(NUM_LINES), .BUS_W(BUS_W)) i_ctl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .trigVec  (trigVec),
    .polVec   (polVec),
    .maskVec  (maskVec),
    .pendVec  (pendVec),
    .strobe   (strobe),
    .wrBits   (wrBits),
    .regRdData(regRdData)
  );

  irq_combiner_dp #(.NUM_LINES(NUM_LINES)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrBits (wrBits),
    .reqIn  (reqIn),
    .trigVec(trigVec),
    .polVec (polVec),
    .maskVec(maskVec),
    .pendVec(pendVec),
    .irqOut (irqOut)
  );

endmodule

// File: tb/test_irq_combiner.sv
module test_irq_combiner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_combiner i_irq_combiner (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // level-mode vectors: polarity, mask, request, expected pending, expected irq
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC][5] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'd0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0004, 32'h0000_0004, 32'd1},
    '{32'hFFFF_FFFF, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004, 32'd0},
    '{32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'd1},
    '{32'h0000_FFFF, 32'hFFFF_0000, 32'h0001_0001, 32'hFFFE_0001, 32'd1},
    '{32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'd1},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0},
    '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 trig", v, 32'h0);
    rd(2'd1, v); chk("R1 pol", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R1 pend", v, 32'h0);
    chk("R1 irq", {31'd0, irqOut}, 32'd0);

    // R3 / R8 level-mode table
    for (int k = 0; k < NVEC; k++) begin
      wr(2'd1, VEC[k][0]);
      wr(2'd2, VEC[k][1]);
      reqIn = VEC[k][2];
      rd(2'd3, v);
      chk($sformatf("R3 vec%0d pend", k), v, VEC[k][3]);
      chk($sformatf("R8 vec%0d irq", k), {31'd0, irqOut}, VEC[k][4]);
    end

    // edge setup: line0 rising, line1 falling (idle high)
    reqIn = 32'h0000_0002;
    wr(2'd2, 32'h0);
    wr(2'd1, 32'hFFFF_FFFD);
    wr(2'd0, 32'h0000_0003);
    @(negedge clk);
    rd(2'd3, v); chk("R10 mode switch no latch", v, 32'h0);

    // R5 rising edge
    reqIn[0] = 1'b1;
    @(negedge clk);
    rd(2'd3, v); chk("R5 rising sets", v, 32'h1);
    chk("R8 irq edge", {31'd0, irqOut}, 32'd1);
    reqIn[0] = 1'b0;
    @(negedge clk);
    rd(2'd3, v); chk("R6 sticky after input drop", v, 32'h1);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R6 zero write keeps", v, 32'h1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R6 one write clears", v, 32'h0);
    chk("R8 irq after clear", {31'd0, irqOut}, 32'd0);

    // R5 falling edge on line1
    reqIn[1] = 1'b0;
    @(negedge clk);
    rd(2'd3, v); chk("R5 falling sets", v, 32'h2);
    wr(2'd3, 32'h2);
    rd(2'd3, v); chk("R6 clear line1", v, 32'h0);

    // R7 edge in the clearing cycle
    reqIn[0] = 1'b1;
    @(negedge clk);
    reqIn[0] = 1'b0;
    @(negedge clk);
    regAddr = 2'd3; regWrData = 32'h1; regWrEn = 1'b1; reqIn[0] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(2'd3, v); chk("R7 edge beats clear", v, 32'h1);

    // R10 held input does not re-latch
    wr(2'd3, 32'h1);
    repeat (2) @(negedge clk);
    rd(2'd3, v); chk("R10 steady input no edge", v, 32'h0);

    // R9 level switch discards latch
    reqIn[0] = 1'b0;
    @(negedge clk);
    reqIn[0] = 1'b1;
    @(negedge clk);
    reqIn[0] = 1'b0;
    rd(2'd3, v); chk("R9 latched before switch", v, 32'h1);
    wr(2'd0, 32'h0000_0002);
    wr(2'd0, 32'h0000_0003);
    rd(2'd3, v); chk("R9 latch discarded", v, 32'h0);

    // R4 clearing an active level line has no effect
    reqIn[2] = 1'b1;
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk("R4 level still pending", v & 32'h4, 32'h4);
    reqIn[2] = 1'b0;
    rd(2'd3, v); chk("R4 level drops with input", v & 32'h4, 32'h0);

    // R2 readback
    wr(2'd2, 32'h1234_5678); rd(2'd2, v); chk("R2 mask readback", v, 32'h1234_5678);
    wr(2'd1, 32'hA5A5_5A5A); rd(2'd1, v); chk("R2 pol readback", v, 32'hA5A5_5A5A);
    wr(2'd0, 32'h0F0F_0000); rd(2'd0, v); chk("R2 trig readback", v, 32'h0F0F_0000);

    // R8 full mask silences
    reqIn = 32'hFFFF_FFFF;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R8 all masked", {31'd0, irqOut}, 32'd0);
    wr(2'd2, 32'hFFFF_FFFE);
    chk("R8 one unmasked", {31'd0, irqOut}, 32'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule